// File: doc/BRIEF.md
# EPROM Byte-Programming Pulse Controller

This block sits between a host and a 4K x 8 UV-erasable programmable ROM. It has two modes. In read mode a start request puts the latched 12-bit address on the device pins and pulls chip enable and output enable low together for a fixed access window. It then captures the byte on the data pins and reports it with a one-cycle valid strobe.

In program mode the output-enable pin is not used as an enable, because it carries the programming supply. The block holds it high and raises a request to enable the roughly 21 V programming supply. A start request latches an address and a byte and drives both for a setup interval. It then issues one active-low chip-enable pulse of fixed length and holds address and data for a hold interval after the pulse. If verify was requested with the start, the block drops the supply request, reads the byte back and flags any difference. The pulse length is `CLK_HZ / 1000 * PULSE_MS` clock cycles, which gives 50 ms by default.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After reset, the chip-enable and output-enable pins are high, the supply request, data drive, busy, done, valid, read data and mismatch outputs are all low, and the address and data pins are zero.
- R2: A start in read mode drives both enables low together for exactly READ_CYC cycles. The byte on the data pins at the end of that window appears on the read-data output, with a one-cycle valid strobe in the cycle after the window. Output enable is never low unless chip enable is low.
- R3: While the block is idle, the supply request follows the mode input one cycle later (1 = program). Whenever the supply request is high, output enable is high.
- R4: A start in program mode drives address and data onto the pins, with chip enable high, for exactly SETUP_CYC cycles before the pulse.
- R5: Each program start produces exactly one chip-enable low pulse, of exactly CLK_HZ/1000*PULSE_MS cycles, while the supply request is high.
- R6: After the pulse, address, data and supply request are held for exactly HOLD_CYC cycles. Without verify, done then pulses for one cycle and the block goes idle.
- R7: Address and data are latched at the start. Changes on the address and data inputs while busy have no effect on the pins.
- R8: With verify, after the hold interval the supply request drops and a READ_CYC-cycle read follows. Done then pulses once, and the mismatch output shows whether the byte read back differs from the byte written. Mismatch is cleared by a program operation without verify.
- R9: Mode changes and start requests made while busy are ignored until the operation ends. The supply request never falls while chip enable is low.
- R10: The block never drives the data pins while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode_i | input | 1 | 1 = program mode, 0 = read mode, sampled while idle |
| start_i | input | 1 | Start one read or one program operation |
| verify_en_i | input | 1 | With a program start: read back and compare |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe at end of a program operation |
| rvalid_o | output | 1 | One-cycle strobe when a read byte is available |
| rdata_o | output | 8 | Last byte read from the device |
| mismatch_o | output | 1 | Last verify read differed from the written byte |
| rom_addr_o | output | 12 | Device address pins |
| rom_dq_o | output | 8 | Data driven toward the device |
| rom_dq_oe_o | output | 1 | Drive enable for the data pins |
| rom_dq_i | input | 8 | Data returned by the device |
| rom_ce_n_o | output | 1 | Device chip enable, active low |
| rom_oe_n_o | output | 1 | Device output enable, active low |
| rom_vpp_en_o | output | 1 | Request to switch on the programming supply |

## Verification
The properties assume a correct timing configuration: every interval parameter is at least one cycle, and the pulse counter in the checker is never reset in the middle of a pulse. The properties place no requirement on the start, mode and data inputs, because the block must ignore any activity on them while busy. The stimulus therefore deliberately toggles the mode input, repeats start and changes address and data during a pulse. It always releases reset between whole operations. The device model in the bench answers only while both enables are low. It programs only when a pulse ends with the supply request high.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_e;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/eprom_phase_timer.sv
module eprom_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  // Loading len makes the phase last exactly len cycles.
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/eprom_seq_fsm.sv
module eprom_seq_fsm
  import eprom_pkg::*;
#(
  parameter int TW        = 8,
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 16,
  parameter int HOLD_CYC  = 4,
  parameter int READ_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          prog_mode_i,
  input  logic          verify_en_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_len_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          cap_vfy_o,
  output logic          clr_mis_o,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          vpp_en_o,
  output logic          dq_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          rvalid_o
);

  phase_e st_q, st_d;
  logic   mode_q, mode_d;
  logic   ver_q;
  logic   vph_q, vph_d;

  assign mode_d    = (st_q == PH_IDLE) ? prog_mode_i : mode_q;
  assign cap_vfy_o = cap_o && vph_q;

  always_comb begin
    st_d       = st_q;
    vph_d      = vph_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    accept_o   = 1'b0;
    cap_o      = 1'b0;
    clr_mis_o  = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (start_i) begin
          accept_o   = 1'b1;
          tmr_load_o = 1'b1;
          vph_d      = 1'b0;
          if (prog_mode_i) begin
            st_d      = PH_SETUP;
            tmr_len_o = TW'(SETUP_CYC);
          end else begin
            st_d      = PH_READ;
            tmr_len_o = TW'(READ_CYC);
          end
        end
      end
      PH_READ: begin
        if (tmr_zero_i) begin
          st_d  = PH_IDLE;
          cap_o = 1'b1;
        end
      end
      PH_SETUP: begin
        if (tmr_zero_i) begin
          st_d       = PH_PULSE;
          tmr_load_o = 1'b1;
          tmr_len_o  = TW'(PULSE_CYC);
        end
      end
      PH_PULSE: begin
        if (tmr_zero_i) begin
          st_d       = PH_HOLD;
          tmr_load_o = 1'b1;
          tmr_len_o  = TW'(HOLD_CYC);
        end
      end
      PH_HOLD: begin
        if (tmr_zero_i) begin
          if (ver_q) begin
            st_d       = PH_READ;
            vph_d      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_len_o  = TW'(READ_CYC);
          end else begin
            st_d      = PH_IDLE;
            clr_mis_o = 1'b1;
          end
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PH_IDLE;
      mode_q   <= 1'b0;
      ver_q    <= 1'b0;
      vph_q    <= 1'b0;
      ce_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      vpp_en_o <= 1'b0;
      dq_oe_o  <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      rvalid_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      vph_q    <= vph_d;
      if (accept_o) ver_q <= verify_en_i;
      ce_n_o   <= !((st_d == PH_READ) || (st_d == PH_PULSE));
      oe_n_o   <= (st_d != PH_READ);
      vpp_en_o <= (st_d inside {PH_SETUP, PH_PULSE, PH_HOLD}) ||
                  ((st_d == PH_IDLE) && mode_d);
      dq_oe_o  <= st_d inside {PH_SETUP, PH_PULSE, PH_HOLD};
      busy_o   <= (st_d != PH_IDLE);
      done_o   <= (cap_o && vph_q) || clr_mis_o;
      rvalid_o <= cap_o && !vph_q;
    end
  end

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int CLK_HZ    = 50_000_000,
  parameter int PULSE_MS  = 50,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 4,
  parameter int READ_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode_i,
  input  logic              start_i,
  input  logic              verify_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [DATA_W-1:0] rom_dq_o,
  output logic              rom_dq_oe_o,
  input  logic [DATA_W-1:0] rom_dq_i,
  output logic              rom_ce_n_o,
  output logic              rom_oe_n_o,
  output logic              rom_vpp_en_o
);

  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;
  localparam int MAX_LEN   = int'(max_of4(SETUP_CYC, PULSE_CYC, HOLD_CYC, READ_CYC));
  localparam int TW        = $clog2(MAX_LEN + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_len;
  logic          accept, cap, cap_vfy, clr_mis;

  eprom_phase_timer #(.TW(TW)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  eprom_seq_fsm #(
    .TW        (TW),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READ_CYC  (READ_CYC)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .prog_mode_i (prog_mode_i),
    .verify_en_i (verify_en_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_len_o   (tmr_len),
    .accept_o    (accept),
    .cap_o       (cap),
    .cap_vfy_o   (cap_vfy),
    .clr_mis_o   (clr_mis),
    .ce_n_o      (rom_ce_n_o),
    .oe_n_o      (rom_oe_n_o),
    .vpp_en_o    (rom_vpp_en_o),
    .dq_oe_o     (rom_dq_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rvalid_o    (rvalid_o)
  );

  // Latched address/data drive the pins; capture and compare on read end.
  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr_o <= '0;
      rom_dq_o   <= '0;
      rdata_o    <= '0;
      mismatch_o <= 1'b0;
    end else begin
      if (accept) begin
        rom_addr_o <= addr_i;
        rom_dq_o   <= wdata_i;
      end
      if (cap) begin
        rdata_o <= rom_dq_i;
        if (cap_vfy) mismatch_o <= (rom_dq_i != rom_dq_o);
      end
      if (clr_mis) mismatch_o <= 1'b0;
    end
  end

endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_en,
  input logic              dq_oe,
  input logic              busy,
  input logic              done,
  input logic              rvalid,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq
);

  localparam int PW = $clog2(PULSE_CYC + 2);

  logic [PW-1:0] plen_q;

  always_ff @(posedge clk) begin
    if (rst)                   plen_q <= '0;
    else if (!ce_n && vpp_en)  plen_q <= plen_q + PW'(1);
    else                       plen_q <= '0;
  end

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ce_n) && $past(vpp_en)) |-> (plen_q == PW'(PULSE_CYC)));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !oe_n));

  // R2
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !ce_n);

  // R3
  vpp_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    vpp_en |-> oe_n);

  // R7
  pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(addr) && $stable(dq)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_rvalid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && rvalid));

  // R9
  vpp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vpp_en) |-> $past(ce_n));

endmodule

bind eprom_prog_ctrl eprom_prog_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PULSE_CYC (PULSE_CYC)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .ce_n   (rom_ce_n_o),
  .oe_n   (rom_oe_n_o),
  .vpp_en (rom_vpp_en_o),
  .dq_oe  (rom_dq_oe_o),
  .busy   (busy_o),
  .done   (done_o),
  .rvalid (rvalid_o),
  .addr   (rom_addr_o),
  .dq     (rom_dq_o)
);

// File: tb/eprom_prog_ctrl_tb.sv
module eprom_prog_ctrl_tb_top;

  localparam int AW = 12, DW = 8;
  localparam int CLK_HZ = 1000, PULSE_MS = 50;
  localparam int SETUP = 3, HOLD = 2, READ = 2;
  localparam int PULSE = (CLK_HZ / 1000) * PULSE_MS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          prog_mode = 1'b0, start = 1'b0, verify_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done, rvalid, mismatch;
  logic [DW-1:0] rdata, rom_dq, rom_dq_in;
  logic [AW-1:0] rom_addr;
  logic          dq_oe, ce_n, oe_n, vpp_en;

  eprom_prog_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS),
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .READ_CYC(READ)
  ) dut_i (
    .clk(clk), .rst(rst), .prog_mode_i(prog_mode), .start_i(start),
    .verify_en_i(verify_en), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rvalid_o(rvalid), .rdata_o(rdata),
    .mismatch_o(mismatch), .rom_addr_o(rom_addr), .rom_dq_o(rom_dq),
    .rom_dq_oe_o(dq_oe), .rom_dq_i(rom_dq_in), .rom_ce_n_o(ce_n),
    .rom_oe_n_o(oe_n), .rom_vpp_en_o(vpp_en)
  );

  // Device model: answers only with both enables low; flip corrupts reads.
  logic [DW-1:0] mem [0:4095];
  logic [DW-1:0] flip = '0;
  assign rom_dq_in = (!ce_n && !oe_n) ? (mem[rom_addr] ^ flip) : '0;

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number and cycles left in it.
  int            ph = 0, left = 0;
  logic          m_mode = 0, m_ver = 0, m_vph = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0, e_rdata = '0, rd;
  logic          e_done = 0, e_rvalid = 0, e_mis = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; left = 0; m_mode = 0; m_ver = 0; m_vph = 0;
      m_addr = '0; m_data = '0; e_rdata = '0;
      e_done = 0; e_rvalid = 0; e_mis = 0;
    end else begin
      e_done = 0; e_rvalid = 0;
      case (ph)
        0: begin
          m_mode = prog_mode;
          if (start) begin
            m_addr = addr; m_data = wdata; m_ver = verify_en; m_vph = 0;
            if (prog_mode) begin ph = 2; left = SETUP; end
            else begin ph = 1; left = READ; end
          end
        end
        1: begin
          left--;
          if (left == 0) begin
            rd = mem[m_addr] ^ flip;
            e_rdata = rd;
            ph = 0;
            if (m_vph) begin e_done = 1; e_mis = (rd != m_data); end
            else e_rvalid = 1;
          end
        end
        2: begin left--; if (left == 0) begin ph = 3; left = PULSE; end end
        3: begin left--; if (left == 0) begin ph = 4; left = HOLD; end end
        default: begin
          left--;
          if (left == 0) begin
            if (m_ver) begin ph = 1; left = READ; m_vph = 1; end
            else begin ph = 0; e_done = 1; e_mis = 0; end
          end
        end
      endcase
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5",  "ce_n",     ce_n,     !(ph == 1 || ph == 3));
      chk("R2",  "oe_n",     oe_n,     (ph != 1));
      chk("R3",  "vpp_en",   vpp_en,   (ph >= 2) || (ph == 0 && m_mode));
      chk("R4",  "dq_oe",    dq_oe,    (ph >= 2));
      chk("R9",  "busy",     busy,     (ph != 0));
      chk("R7",  "rom_addr", rom_addr, m_addr);
      chk("R7",  "rom_dq",   rom_dq,   m_data);
      chk("R6",  "done",     done,     e_done);
      chk("R2",  "rvalid",   rvalid,   e_rvalid);
      chk("R2",  "rdata",    rdata,    e_rdata);
      chk("R8",  "mismatch", mismatch, e_mis);
      chk("R10", "contention", dq_oe & ~oe_n, 0);
    end
  end

  // Programming side of the device model, with pulse-length check.
  int plen = 0, npulse = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!ce_n && vpp_en) plen++;
      else if (plen != 0) begin
        chk("R5", "pulse length", plen, PULSE);
        mem[rom_addr] = mem[rom_addr] & rom_dq;
        npulse++;
        plen = 0;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(logic [AW-1:0] a);
    @(negedge clk);
    prog_mode = 0; repeat (2) @(negedge clk);
    addr = a; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [DW-1:0] d, logic v, logic disturb);
    @(negedge clk);
    prog_mode = 1; addr = a; wdata = d; verify_en = v; start = 1;
    @(negedge clk); start = 0; verify_en = 0;
    if (disturb) begin
      addr = 12'h555; wdata = 8'hC3;
      while (ce_n) @(negedge clk);
      prog_mode = 0; start = 1;
      @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      prog_mode = 1;
    end
    wait_idle();
  endtask

  task automatic run_all();
    int p0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    mem[12'h123] = 8'h5A;
    mem[12'hFFF] = 8'h81;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ce_n",   ce_n, 1);   chk("R1", "oe_n", oe_n, 1);
    chk("R1", "vpp_en", vpp_en, 0); chk("R1", "dq_oe", dq_oe, 0);
    chk("R1", "busy",   busy, 0);   chk("R1", "done", done, 0);
    chk("R1", "rvalid", rvalid, 0); chk("R1", "rdata", rdata, 0);
    chk("R1", "mismatch", mismatch, 0); chk("R1", "rom_addr", rom_addr, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    do_read(12'h123);
    chk("R2", "read 123", rdata, 8'h5A);
    do_read(12'hFFF);
    chk("R2", "read FFF", rdata, 8'h81);

    // R3: idle supply request follows mode
    prog_mode = 1; repeat (2) @(negedge clk);
    chk("R3", "vpp idle prog", vpp_en, 1);
    chk("R3", "oe_n idle prog", oe_n, 1);

    p0 = npulse;
    do_prog(12'h010, 8'h3C, 0, 1);
    chk("R5", "one pulse per start", npulse - p0, 1);
    chk("R7", "byte at latched addr", mem[12'h010], 8'h3C);
    chk("R7", "disturb addr untouched", mem[12'h555], 8'hFF);

    do_prog(12'h011, 8'hA5, 1, 0);
    chk("R8", "verify match", mismatch, 0);

    flip = 8'h04;
    do_prog(12'h012, 8'h0F, 1, 0);
    chk("R8", "verify mismatch", mismatch, 1);
    flip = 8'h00;

    do_prog(12'h013, 8'h77, 0, 0);
    chk("R8", "mismatch cleared", mismatch, 0);
    chk("R6", "byte 013", mem[12'h013], 8'h77);

    do_read(12'h010);
    chk("R2", "read back 010", rdata, 8'h3C);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule